// File: doc/BRIEF.md
# Dithered Cosine Carrier with Amplitude Modulation and One-Bit Output

This block turns a frequency word and a stream of signed amplitude samples into a single output bit whose running density of ones carries an amplitude-modulated carrier. A wide phase accumulator advances by the frequency word every clock. A pseudo-random word from a shift-register generator is added to the low part of the phase before the top bits are taken as the address of a cosine table. The table stores one quarter of a period and rebuilds the other three quarters by symmetry.

Each table sample is multiplied by the current amplitude sample and scaled back to the sample width. The product, shifted into an unsigned range, feeds a first-order sigma-delta accumulator. The carry out of that accumulator is the output bit. No digital-to-analog converter is needed: a simple low-pass filter on the bit stream recovers the modulated carrier. The phase-dither noise passes through the multiplier and also breaks up the limit cycles of the sigma-delta stage.

Top module: `am_bitstream_dds`

## Requirements
- R1: The phase register is 24 bits wide and resets to 0. Every clock it adds the zero-extended 23-bit frequency word, modulo 2^24.
- R2: The dither source is a 16-bit Galois shift register seeded with 0xACE1 at reset. Each clock it shifts right, and when the bit shifted out is 1 it XORs in 0xB400. Its low 12 bits are added to the phase, modulo 2^24, and the top 12 bits of that sum form the table address.
- R3: The table at address k holds round((2^23-1)·cos(2π(k+0.5)/4096)) as a signed 24-bit value. Quarter q (address bits 11:10) with low part l reads the first-quarter entry at l for q=0 and q=2, and at 1023-l for q=1 and q=3. The value is negated for q=1 and q=2. Every entry is within one LSB of the exact cosine and never reaches -2^23.
- R4: The amplitude input is 12-bit two's complement. The value -2048 behaves exactly like -2047.
- R5: The product is floor(sample·amplitude/2048) as a signed 24-bit value. A zero amplitude gives a zero product.
- R6: The sigma-delta accumulator is 24 bits wide and resets to 0. Each clock it adds product+2^23, modulo 2^24. The output bit is the registered carry of that addition. Over any window of W clocks with a constant product p, the count of ones differs from W·(p+2^23)/2^24 by at most one.
- R7: The output is 0 during reset. Each stage is registered: phase/dither, table sample, product, accumulator/carry. An amplitude sampled at clock edge k reaches the output after edge k+1. A frequency word sampled at edge k reaches the output after edge k+3.
- R8: With a zero amplitude from reset, the output after the n-th clock edge following reset release is 1 for even n and 0 for odd n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fcw | input | 23 | Unsigned frequency word added to the phase each clock |
| amp | input | 12 | Signed amplitude sample, two's complement |
| bit_out | output | 1 | Registered sigma-delta carry, the one-bit modulated output |

## Verification
Two things can happen in the same clock: a new amplitude sample reaches the multiplier, and a dither value carries across a table address boundary. When both occur together, a wrong stage alignment would mix an old sample with a new gain. To provoke this, the bench changes the amplitude every 37 clocks while several frequency words sweep the phase across quarter and address boundaries, with the dither always running. Each output bit is compared with a cycle-exact arithmetic model computed in the bench from the stated rules. Separately, density windows with a frozen phase check the ones count against the arithmetic level, and an address sweep of the table checks every entry against a real-valued cosine.

// File: rtl/dds_am_pkg.sv
package dds_am_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // First-quarter cosine magnitude, rounded to nearest, half-sample offset
    function automatic longint cos_quarter_value(input int idx, input int depth, input longint peak);
        real ang;
        ang = TWO_PI * (real'(idx) + 0.5) / real'(depth);
        return longint'($floor(real'(peak) * $cos(ang) + 0.5));
    endfunction

endpackage

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr #(
    parameter int              LFSR_W = 16,
    parameter logic [15:0]     TAPS   = 16'hB400,
    parameter logic [15:0]     SEED   = 16'hACE1,
    parameter int              OUT_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] dither
);

    typedef struct packed {
        logic [LFSR_W-1:0] shreg;
    } lfsr_state_t;

    lfsr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.shreg[0]) begin
            st_d.shreg = (st_q.shreg >> 1) ^ LFSR_W'(TAPS);
        end else begin
            st_d.shreg = st_q.shreg >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.shreg <= LFSR_W'(SEED);
        end else begin
            st_q <= st_d;
        end
    end

    assign dither = st_q.shreg[OUT_W-1:0];

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst)
        st_q.shreg != '0); // R2

endmodule

// File: rtl/dds_carrier_rom.sv
module dds_carrier_rom
    import dds_am_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [DATA_W-1:0] sample
);

    localparam int     QUART_W = ADDR_W - 2;
    localparam int     QDEPTH  = 1 << QUART_W;
    localparam int     DEPTH   = 1 << ADDR_W;
    localparam int     MAG_W   = DATA_W - 1;
    localparam longint PEAK    = (longint'(1) << (DATA_W - 1)) - 1;

    typedef struct packed {
        logic signed [DATA_W-1:0] sample;
    } rom_state_t;

    rom_state_t st_d, st_q;

    logic [MAG_W-1:0]   quarter [QDEPTH];
    logic [1:0]         quad;
    logic [QUART_W-1:0] low;
    logic [QUART_W-1:0] mirror;
    logic [MAG_W-1:0]   mag;
    logic               negate;

    for (genvar g = 0; g < QDEPTH; g++) begin : g_quarter
        assign quarter[g] = MAG_W'(cos_quarter_value(g, DEPTH, PEAK));
    end

    always_comb begin
        quad   = addr[ADDR_W-1 -: 2];
        low    = addr[QUART_W-1:0];
        mirror = quad[0] ? ~low : low;
        mag    = quarter[mirror];
        negate = quad[1] ^ quad[0];
        st_d   = st_q;
        if (negate) begin
            st_d.sample = -$signed({1'b0, mag});
        end else begin
            st_d.sample = $signed({1'b0, mag});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sample <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = st_q.sample;

    AST_SAMPLE_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
        st_q.sample != {1'b1, {MAG_W{1'b0}}}); // R3

    AST_ZERO_ADDR_PEAK: assert property (@(posedge clk) disable iff (rst)
        (addr == '0) |=> (st_q.sample > 0)); // R3

endmodule

// File: rtl/dds_am_scaler.sv
module dds_am_scaler #(
    parameter int SAMP_W = 24,
    parameter int AMP_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [SAMP_W-1:0] sample,
    input  logic signed [AMP_W-1:0]  amp,
    output logic signed [SAMP_W-1:0] product
);

    localparam int PROD_W = SAMP_W + AMP_W;
    localparam logic [AMP_W-1:0] AMP_MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    typedef struct packed {
        logic signed [SAMP_W-1:0] product;
    } mult_state_t;

    mult_state_t st_d, st_q;

    logic [AMP_W-1:0]  amp_sat;
    logic [PROD_W-1:0] full;

    always_comb begin
        if (amp == AMP_MOST_NEG) begin
            amp_sat = AMP_MOST_NEG + AMP_W'(1);
        end else begin
            amp_sat = amp;
        end
        full = {{AMP_W{sample[SAMP_W-1]}}, sample} * {{SAMP_W{amp_sat[AMP_W-1]}}, amp_sat};
        st_d = st_q;
        st_d.product = $signed(full[AMP_W-1 +: SAMP_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.product <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign product = st_q.product;

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
        (amp == '0) |=> (st_q.product == '0)); // R5

    AST_PRODUCT_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
        st_q.product != {1'b1, {(SAMP_W-1){1'b0}}}); // R4

endmodule

// File: rtl/dds_sigma_delta.sv
module dds_sigma_delta #(
    parameter int IN_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] level,
    output logic                   bit_out
);

    typedef struct packed {
        logic [IN_W-1:0] acc;
        logic            carry;
    } sd_state_t;

    sd_state_t st_d, st_q;

    logic [IN_W-1:0] biased;
    logic [IN_W:0]   sum;

    always_comb begin
        biased = {~level[IN_W-1], level[IN_W-2:0]};
        sum    = {1'b0, st_q.acc} + {1'b0, biased};
        st_d       = st_q;
        st_d.acc   = sum[IN_W-1:0];
        st_d.carry = sum[IN_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc   <= '0;
            st_q.carry <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.carry;

    AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (rst)
        st_q.carry |-> (st_q.acc < $past(st_q.acc))); // R6

    AST_NO_CARRY_GROWS: assert property (@(posedge clk) disable iff (rst)
        !st_q.carry |-> (st_q.acc >= $past(st_q.acc))); // R6

endmodule

// File: rtl/am_bitstream_dds.sv
module am_bitstream_dds #(
    parameter int          PHASE_W   = 24,
    parameter int          FCW_W     = 23,
    parameter int          ADDR_W    = 12,
    parameter int          SAMP_W    = 24,
    parameter int          AMP_W     = 12,
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [FCW_W-1:0]        fcw,
    input  logic signed [AMP_W-1:0] amp,
    output logic                    bit_out
);

    localparam int DITH_W = PHASE_W - ADDR_W;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } phase_state_t;

    phase_state_t st_d, st_q;

    logic [DITH_W-1:0]        dither;
    logic [PHASE_W-1:0]       dithered;
    logic [ADDR_W-1:0]        rom_addr;
    logic signed [SAMP_W-1:0] carrier;
    logic signed [SAMP_W-1:0] level;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + PHASE_W'(fcw);
        dithered   = st_q.phase + PHASE_W'(dither);
        rom_addr   = dithered[PHASE_W-1 -: ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dds_dither_lfsr #(
        .LFSR_W (LFSR_W),
        .TAPS   (LFSR_TAPS),
        .SEED   (LFSR_SEED),
        .OUT_W  (DITH_W)
    ) u_dither (
        .clk    (clk),
        .rst    (rst),
        .dither (dither)
    );

    dds_carrier_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (SAMP_W)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr   (rom_addr),
        .sample (carrier)
    );

    dds_am_scaler #(
        .SAMP_W (SAMP_W),
        .AMP_W  (AMP_W)
    ) u_scaler (
        .clk     (clk),
        .rst     (rst),
        .sample  (carrier),
        .amp     (amp),
        .product (level)
    );

    dds_sigma_delta #(
        .IN_W (SAMP_W)
    ) u_sd (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .bit_out (bit_out)
    );

    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fcw == '0) |=> $stable(st_q.phase)); // R1

endmodule

// File: tb/am_bitstream_dds_test.sv
module am_bitstream_dds_test;

    localparam longint TWO24 = longint'(1) << 24;
    localparam longint HALF  = longint'(1) << 23;
    localparam longint PEAK  = HALF - 1;
    localparam real    TWOPI = 6.283185307179586;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [22:0]       fcw = '0;
    logic signed [11:0] amp = '0;
    logic              bit_out;
    logic [11:0]       rom_addr = '0;
    logic signed [23:0] rom_sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    longint qtab [1024];
    longint m_lfsr, m_phase, m_sample, m_prod, m_acc;
    bit     m_bit;
    bit     seq_a [2000];

    always #10 clk = ~clk;

    am_bitstream_dds uut (
        .clk(clk), .rst(rst), .fcw(fcw), .amp(amp), .bit_out(bit_out)
    );

    dds_carrier_rom #(.ADDR_W(12), .DATA_W(24)) rom_uut (
        .clk(clk), .rst(rst), .addr(rom_addr), .sample(rom_sample)
    );

    function automatic longint table_at(input longint a);
        longint q, l, m;
        q = (a >> 10) & 3;
        l = a & 1023;
        m = (q == 1 || q == 3) ? (1023 - l) : l;
        return (q == 1 || q == 2) ? -qtab[m] : qtab[m];
    endfunction

    function automatic longint amp_eff(input longint a);
        return (a == -2048) ? -2047 : a;
    endfunction

    task automatic model_reset();
        m_lfsr = 64'hACE1; m_phase = 0; m_sample = 0; m_prod = 0; m_acc = 0; m_bit = 0;
    endtask

    // one rising edge with inputs f, a held
    task automatic model_step(input longint f, input longint a);
        longint addr, ns, np, s, nl;
        addr = ((m_phase + (m_lfsr & 4095)) % TWO24) >> 12;
        ns   = table_at(addr);
        np   = (m_sample * amp_eff(a)) >>> 11;
        s    = m_acc + m_prod + HALF;
        nl   = (m_lfsr & 1) ? ((m_lfsr >> 1) ^ 64'hB400) : (m_lfsr >> 1);
        m_bit    = (s >= TWO24);
        m_acc    = s % TWO24;
        m_prod   = np;
        m_sample = ns;
        m_phase  = (m_phase + f) % TWO24;
        m_lfsr   = nl;
    endtask

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one clock: edge, model update, sample at falling edge
    task automatic tick();
        @(posedge clk);
        model_step(longint'(fcw), longint'(amp));
        @(negedge clk);
    endtask

    task automatic model_run(input logic [22:0] f, input int cycles);
        int  bad_at;
        bit  act_b, exp_b;
        longint amps [9] = '{-2048, -2047, -1, 0, 1, 2047, 1024, -700, 333};
        bad_at = -1;
        fcw = f; amp = 12'(amps[0]);
        do_reset();
        for (int c = 0; c < cycles; c++) begin
            if (c % 37 == 0) amp = 12'(amps[(c / 37) % 9]);
            tick();
            if (bad_at < 0 && bit_out !== m_bit) begin
                bad_at = c; act_b = bit_out; exp_b = m_bit;
            end
        end
        // R1 R2 R5 R7: bit-exact against the arithmetic model
        check(bad_at < 0, "R7", $sformatf("bit stream fcw=%0d first mismatch cycle %0d", f, bad_at),
              longint'(act_b), longint'(exp_b));
    endtask

    task automatic density(input logic signed [11:0] a);
        longint prod, u, ones, err;
        fcw = '0; amp = a;
        do_reset();
        repeat (8) tick();
        ones = 0;
        for (int c = 0; c < 8192; c++) begin
            tick();
            ones += longint'(bit_out);
        end
        prod = (qtab[0] * amp_eff(longint'(a))) >>> 11;
        u    = prod + HALF;
        err  = ones * TWO24 - 8192 * u;
        if (err < 0) err = -err;
        check(err <= TWO24, "R6", $sformatf("ones density amp=%0d", a), ones, (8192 * u) / TWO24);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++)
            qtab[i] = longint'($floor(real'(PEAK) * $cos(TWOPI * (real'(i) + 0.5) / 4096.0) + 0.5));

        // R7: output low while in reset
        repeat (3) @(negedge clk);
        check(bit_out == 1'b0, "R7", "output in reset", longint'(bit_out), 0);

        // R3: full table sweep against real cosine
        begin
            int badn;
            badn = 0;
            for (int i = 0; i < 4096; i++) begin
                real exact;
                @(negedge clk);
                rst = 1'b0;
                rom_addr = 12'(i);
                @(negedge clk);
                exact = real'(PEAK) * $cos(TWOPI * (real'(i) + 0.5) / 4096.0);
                if ((real'(rom_sample) - exact > 1.0) || (exact - real'(rom_sample) > 1.0)
                    || rom_sample == -24'sd8388608) begin
                    badn++;
                    if (badn < 4) check(1'b0, "R3", $sformatf("table entry %0d", i),
                                        longint'(rom_sample), longint'($rtoi(exact)));
                end
            end
            check(badn == 0, "R3", "table entries out of tolerance", badn, 0);
        end

        // R8: zero amplitude gives strict alternation from reset
        begin
            int bad;
            bad = -1;
            fcw = 23'd5000; amp = '0;
            do_reset();
            for (int n = 1; n <= 300; n++) begin
                tick();
                if (bad < 0 && bit_out !== ((n % 2) == 0)) bad = n;
            end
            check(bad < 0, "R8", "alternation first bad edge", bad, -1);
        end

        // R1 R2 R5 R7: cycle-exact runs, amplitude changing mid-carrier
        model_run(23'd0, 1500);
        model_run(23'd1, 2500);
        model_run(23'd12345, 3000);
        model_run(23'h400000, 2000);
        model_run(23'h7FFFFF, 3000);
        model_run(23'h400007, 3000);

        // R4: -2048 and -2047 give identical bit streams
        begin
            int diff;
            diff = -1;
            fcw = 23'd12345; amp = -12'sd2048;
            do_reset();
            for (int c = 0; c < 2000; c++) begin
                tick();
                seq_a[c] = bit_out;
            end
            amp = -12'sd2047;
            do_reset();
            for (int c = 0; c < 2000; c++) begin
                tick();
                if (diff < 0 && seq_a[c] !== bit_out) diff = c;
            end
            check(diff < 0, "R4", "saturation stream first difference", diff, -1);
        end

        // R6 R5: density windows with a frozen phase
        density(12'sd0);
        density(12'sd2047);
        density(-12'sd2047);
        density(-12'sd2048);
        density(12'sd1024);
        density(-12'sd333);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule